// File: doc/BRIEF.md
# Selectable Unipolar/Bipolar Transmit Line Coder

This block is the transmit data front end of one T1/E1 line channel. A framer hands it data in one of two shapes. In bipolar operation the framer has already done the line coding and drives a positive rail and a negative rail. The block maps that pair onto a registered mark pair and flags the one combination that makes no sense. In unipolar operation the framer drives a single NRZ bit stream. The block then does the coding itself: plain alternate mark inversion, or alternate mark inversion with zero substitution. The substitution is the eight-zero pattern for T1 or the four-zero pattern for E1.

The operating mode comes from a select input that is qualified against the transmit clock. The three-state controller works as follows. It rests in MODE_BIPOLAR while the select is low. On the first high sample it moves to MODE_QUALIFY. It counts consecutive high samples there, and any low sample sends it back to MODE_BIPOLAR. It reaches MODE_UNIPOLAR on the sixteenth consecutive high sample. A single low sample in MODE_UNIPOLAR returns it at once to MODE_BIPOLAR. In the unipolar path a look-ahead window of four bits (E1) or eight bits (T1) holds the stream long enough for a whole run of zeros to be seen and rewritten before its first bit leaves. The window is emptied to spaces whenever unipolar operation is not active or the coding settings change. There is no loss-of-signal input, so nothing can gate the transmit path.

Top module: `tx_line_coder`

## Requirements
- R1: During and after a synchronous reset (`rst` high), `pos_out`, `neg_out` and `illegal_out` are 0 and the block is in bipolar mode. The remembered polarity of the last mark is negative and the HDB3 mark-count parity is even, so the first unipolar mark after reset is positive.
- R2: In bipolar mode the output follows the rails one clock after sampling. `pos_in`=1 and `neg_in`=0 give `pos_out`=1. `pos_in`=0 and `neg_in`=1 give `neg_out`=1. Both rails at 0 give a space (both outputs 0).
- R3: In bipolar mode, both rails at 1 give a space and set `illegal_out` to 1 for that one output cycle. `illegal_out` is 0 for every other combination.
- R4: With `uni_req` low the block is bipolar. Unipolar operation starts with the clock edge that follows the sixteenth consecutive high sample of `uni_req`. A low sample before that restarts the count. A low sample during unipolar operation makes the next clock edge bipolar again.
- R5: During unipolar operation `pos_in` and `neg_in` have no effect on the output, and `illegal_out` stays 0.
- R6: With `sub_en`=0 the unipolar coder is plain AMI. Each 1 becomes a mark of the polarity opposite to the previous mark, and each 0 becomes a space. The latency from sampling `data_in` to the output is 4 clocks with `e1_mode`=1 and 8 clocks with `e1_mode`=0.
- R7: With `sub_en`=1 and `e1_mode`=0, every run of eight zeros taken from the start of the run is sent as 0,0,0,V,B,0,V,B. V has the same polarity as the mark before it, and B has the polarity opposite to the mark before it. The latency is 8 clocks.
- R8: With `sub_en`=1 and `e1_mode`=1, every run of four zeros is sent as 0,0,0,V if an odd number of marks has been sent since the last V, and as B,0,0,V if that number is even. Parity counts both 1-marks and B-marks and restarts at V. The latency is 4 clocks.
- R9: The unipolar window starts empty on entry to unipolar mode, so the first 4 or 8 outputs are spaces. The first edge that sees a change of `sub_en` or `e1_mode` during unipolar operation does three things: it sends a space, discards the bits still in the window together with the bit sampled at that edge, and keeps the mark polarity. The first bit sampled after that edge appears after the new latency.
- R10: `pos_out` and `neg_out` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| uni_req | input | 1 | Mode select: low for bipolar, held high to request unipolar |
| sub_en | input | 1 | Unipolar coding: 0 plain AMI, 1 with zero substitution |
| e1_mode | input | 1 | Substitution type and window depth: 1 E1 (HDB3, 4), 0 T1 (B8ZS, 8) |
| data_in | input | 1 | Unipolar NRZ data bit |
| pos_in | input | 1 | Bipolar positive rail |
| neg_in | input | 1 | Bipolar negative rail |
| pos_out | output | 1 | Registered positive mark |
| neg_out | output | 1 | Registered negative mark |
| illegal_out | output | 1 | Registered flag: both bipolar rails were high |

## Verification
The hardest situations to reach from the ports are the HDB3 choice between 000V and B00V and a settings change while bits are still inside the window. The first depends on mark parity that is never visible directly. The second needs the window to be partly full at the moment of the change. The bench feeds whole bit streams with zero runs of lengths 1 to 16, plus a zero-biased pseudo-random stream, through every coding setting. It derives the expected mark sequence by scanning each stream from left to right with its own polarity and parity tally, so both parity states recur many times. It also flips the depth setting in the middle of an all-ones AMI stream to catch the discarded bits and the new latency.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;

    typedef enum logic [1:0] {
        MODE_BIPOLAR,
        MODE_QUALIFY,
        MODE_UNIPOLAR
    } mode_state_t;

    typedef enum logic [1:0] {
        SYM_ZERO,
        SYM_ONE,
        SYM_VIOL,
        SYM_BAL
    } sym_t;

    // zero-run lengths that trigger substitution (also the window depths)
    localparam int RUN_T1 = 8;
    localparam int RUN_E1 = 4;

endpackage

// File: rtl/lc_mode_qual.sv
`timescale 1ns/1ps
module lc_mode_qual
    import lc_pkg::*;
#(
    parameter int QUAL_COUNT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_hi,
    output logic uni_active
);

    localparam int CW = $clog2(QUAL_COUNT + 1);

    mode_state_t    state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MODE_BIPOLAR;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            MODE_BIPOLAR: begin
                if (sel_hi) begin
                    state_nx = MODE_QUALIFY;
                    cnt_nx   = CW'(1);
                end
            end
            MODE_QUALIFY: begin
                if (!sel_hi) begin
                    state_nx = MODE_BIPOLAR;
                    cnt_nx   = '0;
                end else if (cnt == CW'(QUAL_COUNT - 1)) begin
                    state_nx = MODE_UNIPOLAR;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            MODE_UNIPOLAR: begin
                if (!sel_hi) begin
                    state_nx = MODE_BIPOLAR;
                end
            end
            default: begin
                state_nx = MODE_BIPOLAR;
                cnt_nx   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        uni_active = (state == MODE_UNIPOLAR);
    end

endmodule

// File: rtl/lc_sub_window.sv
`timescale 1ns/1ps
module lc_sub_window
    import lc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic din,
    input  logic long_run,
    input  logic subst_en,
    input  logic parity_odd,
    output logic head_valid,
    output sym_t head_sym
);

    localparam int DEPTH   = RUN_T1;
    localparam int HEAD_T1 = RUN_T1 - 1;
    localparam int HEAD_E1 = RUN_E1 - 1;

    logic [DEPTH-1:0] vld;
    sym_t             sym [DEPTH];
    sym_t             win [DEPTH];
    logic             zeros_t1, zeros_e1;

    // index 0 is newest; oldest-first pattern 0 0 0 V B 0 V B
    function automatic sym_t t1_pat(input int idx);
        if (idx == 4 || idx == 1)      return SYM_VIOL;
        else if (idx == 3 || idx == 0) return SYM_BAL;
        else                           return SYM_ZERO;
    endfunction

    // oldest-first pattern (B|0) 0 0 V
    function automatic sym_t e1_pat(input int idx, input logic odd);
        if (idx == 0)               return SYM_VIOL;
        else if (idx == RUN_E1 - 1) return odd ? SYM_ZERO : SYM_BAL;
        else                        return SYM_ZERO;
    endfunction

    always_comb begin
        zeros_t1 = 1'b1;
        zeros_e1 = 1'b1;
        for (int i = 0; i < RUN_T1; i++) begin
            if (!vld[i] || sym[i] != SYM_ZERO) zeros_t1 = 1'b0;
        end
        for (int i = 0; i < RUN_E1; i++) begin
            if (!vld[i] || sym[i] != SYM_ZERO) zeros_e1 = 1'b0;
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            win[i] = sym[i];
        end
        if (subst_en && long_run && zeros_t1) begin
            for (int i = 0; i < RUN_T1; i++) begin
                win[i] = t1_pat(i);
            end
        end else if (subst_en && !long_run && zeros_e1) begin
            for (int i = 0; i < RUN_E1; i++) begin
                win[i] = e1_pat(i, parity_odd);
            end
        end
    end

    always_comb begin
        if (long_run) begin
            head_valid = vld[HEAD_T1];
            head_sym   = win[HEAD_T1];
        end else begin
            head_valid = vld[HEAD_E1];
            head_sym   = win[HEAD_E1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                sym[i] <= SYM_ZERO;
            end
        end else begin
            vld    <= {vld[DEPTH-2:0], 1'b1};
            sym[0] <= din ? SYM_ONE : SYM_ZERO;
            for (int i = 1; i < DEPTH; i++) begin
                sym[i] <= win[i-1];
            end
        end
    end

endmodule

// File: rtl/lc_mark_pol.sv
`timescale 1ns/1ps
module lc_mark_pol
    import lc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  sym_t sym,
    output logic mark_p,
    output logic mark_n,
    output logic parity_odd
);

    logic last_pos;
    logic par;

    always_comb begin
        mark_p = 1'b0;
        mark_n = 1'b0;
        if (en) begin
            unique case (sym)
                SYM_ONE, SYM_BAL: begin
                    mark_p = !last_pos;
                    mark_n = last_pos;
                end
                SYM_VIOL: begin
                    mark_p = last_pos;
                    mark_n = !last_pos;
                end
                SYM_ZERO: begin
                    mark_p = 1'b0;
                    mark_n = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pos <= 1'b0;
            par      <= 1'b0;
        end else if (en) begin
            unique case (sym)
                SYM_ONE, SYM_BAL: begin
                    last_pos <= !last_pos;
                    par      <= !par;
                end
                SYM_VIOL: par <= 1'b0;
                SYM_ZERO: par <= par;
            endcase
        end
    end

    always_comb parity_odd = par;

endmodule

// File: rtl/tx_line_coder.sv
`timescale 1ns/1ps
module tx_line_coder
    import lc_pkg::*;
#(
    parameter int QUAL_COUNT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic uni_req,
    input  logic sub_en,
    input  logic e1_mode,
    input  logic data_in,
    input  logic pos_in,
    input  logic neg_in,
    output logic pos_out,
    output logic neg_out,
    output logic illegal_out
);

    logic       uni_active;
    logic [1:0] cfg_q;
    logic       cfg_chg;
    logic       flush;
    logic       head_valid;
    sym_t       head_sym;
    logic       pol_en;
    logic       mark_p, mark_n, parity_odd;
    logic       pos_nx, neg_nx, ill_nx;

    lc_mode_qual #(.QUAL_COUNT(QUAL_COUNT)) u_qual (
        .clk        (clk),
        .rst        (rst),
        .sel_hi     (uni_req),
        .uni_active (uni_active)
    );

    always_comb begin
        cfg_chg = ({sub_en, e1_mode} != cfg_q);
        flush   = !uni_active || cfg_chg;
        pol_en  = !flush && head_valid;
    end

    lc_sub_window u_win (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .din        (data_in),
        .long_run   (!e1_mode),
        .subst_en   (sub_en),
        .parity_odd (parity_odd),
        .head_valid (head_valid),
        .head_sym   (head_sym)
    );

    lc_mark_pol u_pol (
        .clk        (clk),
        .rst        (rst),
        .en         (pol_en),
        .sym        (head_sym),
        .mark_p     (mark_p),
        .mark_n     (mark_n),
        .parity_odd (parity_odd)
    );

    always_comb begin
        if (uni_active) begin
            pos_nx = mark_p;
            neg_nx = mark_n;
            ill_nx = 1'b0;
        end else begin
            pos_nx = pos_in && !neg_in;
            neg_nx = neg_in && !pos_in;
            ill_nx = pos_in && neg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= 2'b00;
            pos_out     <= 1'b0;
            neg_out     <= 1'b0;
            illegal_out <= 1'b0;
        end else begin
            cfg_q       <= {sub_en, e1_mode};
            pos_out     <= pos_nx;
            neg_out     <= neg_nx;
            illegal_out <= ill_nx;
        end
    end

endmodule

// File: rtl/tx_line_coder_chk.sv
`timescale 1ns/1ps
module tx_line_coder_chk #(
    parameter int QUAL_COUNT = 16
) (
    input logic clk,
    input logic rst,
    input logic uni_req,
    input logic pos_in,
    input logic neg_in,
    input logic pos_out,
    input logic neg_out,
    input logic illegal_out
);

    localparam int CW = $clog2(QUAL_COUNT + 1);

    logic [CW-1:0] run;
    logic [1:0]    age;

    // consecutive high samples of the mode select, saturating
    always_ff @(posedge clk) begin
        if (rst || !uni_req) run <= '0;
        else if (run != CW'(QUAL_COUNT)) run <= run + CW'(1);
    end

    // clean edges since reset, saturating at 3
    always_ff @(posedge clk) begin
        if (rst) age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!pos_out && !neg_out && !illegal_out));

    assert_bipolar_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !$past(uni_req, 2)) |->
            (pos_out == ($past(pos_in) && !$past(neg_in)) &&
             neg_out == ($past(neg_in) && !$past(pos_in))));

    assert_illegal_space_R3: assert property (@(posedge clk) disable iff (rst)
        illegal_out |-> (!pos_out && !neg_out));

    assert_qualify_window_R4: assert property (@(posedge clk) disable iff (rst)
        illegal_out |-> ($past(run) < CW'(QUAL_COUNT)));

    assert_rails_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(run) == CW'(QUAL_COUNT)) |-> !illegal_out);

    assert_one_mark_R10: assert property (@(posedge clk) disable iff (rst)
        !(pos_out && neg_out));

endmodule

bind tx_line_coder tx_line_coder_chk #(.QUAL_COUNT(QUAL_COUNT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .uni_req     (uni_req),
    .pos_in      (pos_in),
    .neg_in      (neg_in),
    .pos_out     (pos_out),
    .neg_out     (neg_out),
    .illegal_out (illegal_out)
);

// File: tb/tx_line_coder_tb.sv
`timescale 1ns/1ps
module tx_line_coder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAXN = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic uni_req = 1'b0, sub_en = 1'b0, e1_mode = 1'b0;
    logic data_in = 1'b0, pos_in = 1'b0, neg_in = 1'b0;
    logic pos_out, neg_out, illegal_out;

    int checks = 0;
    int errors = 0;

    bit   bits [MAXN];
    bit   ep   [MAXN];
    bit   en   [MAXN];
    int   nbits;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_line_coder u_dut (
        .clk(clk), .rst(rst), .uni_req(uni_req), .sub_en(sub_en),
        .e1_mode(e1_mode), .data_in(data_in), .pos_in(pos_in),
        .neg_in(neg_in), .pos_out(pos_out), .neg_out(neg_out),
        .illegal_out(illegal_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {pos_out, neg_out, illegal_out};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got pos/neg/ill=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; uni_req = 1'b0; data_in = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
        tick();
        tick();
        chk("R1 reset outputs", 3'b000);
        rst = 1'b0;
    endtask

    task automatic qualify();
        uni_req = 1'b1; pos_in = 1'b0; neg_in = 1'b0;
        repeat (16) tick();
    endtask

    // expected stream from the coding rules, left-to-right scan
    task automatic build_expected(input bit sub, input bit e1);
        int  d, i, blk;
        bit  last_pos, par, allz;
        int  sy [MAXN];
        d = e1 ? 4 : 8;
        last_pos = 1'b0; par = 1'b0; i = 0;
        while (i < nbits) begin
            allz = sub && (i + d <= nbits);
            if (allz) begin
                for (int j = 0; j < d; j++) if (bits[i+j]) allz = 1'b0;
            end
            if (allz) begin
                for (int j = 0; j < d; j++) begin
                    if (!e1) sy[i+j] = (j == 3 || j == 6) ? 2 : (j == 4 || j == 7) ? 3 : 0;
                    else     sy[i+j] = (j == 3) ? 2 : (j == 0 && !par) ? 3 : 0;
                end
                blk = d;
            end else begin
                sy[i] = bits[i] ? 1 : 0;
                blk = 1;
            end
            for (int j = 0; j < blk; j++) begin
                ep[i+j] = 1'b0; en[i+j] = 1'b0;
                if (sy[i+j] == 1 || sy[i+j] == 3) begin
                    ep[i+j] = !last_pos; en[i+j] = last_pos;
                    last_pos = !last_pos; par = !par;
                end else if (sy[i+j] == 2) begin
                    ep[i+j] = last_pos; en[i+j] = !last_pos;
                    par = 1'b0;
                end
            end
            i += blk;
        end
    endtask

    task automatic run_stream(input bit sub, input bit e1, input string tag);
        int d;
        d = e1 ? 4 : 8;
        sub_en = sub; e1_mode = e1;
        do_reset();
        qualify();
        build_expected(sub, e1);
        for (int k = 0; k < nbits + d; k++) begin
            data_in = (k < nbits) ? bits[k] : 1'b1;
            pos_in = 1'b1; neg_in = 1'b1;   // R5: rails must not matter
            tick();
            if (k < d) chk("R9 empty window on entry", 3'b000);
            else       chk(tag, {ep[k-d], en[k-d], 1'b0});
        end
        uni_req = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
        tick();
    endtask

    task automatic all_cfgs(input string pname);
        run_stream(1'b0, 1'b1, {"R6 AMI depth4 ", pname});
        run_stream(1'b0, 1'b0, {"R6 AMI depth8 ", pname});
        run_stream(1'b1, 1'b0, {"R7 B8ZS ", pname});
        run_stream(1'b1, 1'b1, {"R8 HDB3 ", pname});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int runs [10] = '{1, 3, 4, 5, 7, 8, 9, 12, 16, 2};
        logic [15:0] lfsr;
        int idx, c;
        int m;

        @(negedge clk);
        do_reset();

        // R2, R3: sweep of rail combinations, one clock latency
        for (int rep = 0; rep < 4; rep++) begin
            for (int v = 0; v < 4; v++) begin
                pos_in = v[1]; neg_in = v[0];
                tick();
                chk(v == 3 ? "R3 both rails" : "R2 rail map",
                    {v[1] && !v[0], v[0] && !v[1], v[1] && v[0]});
            end
        end

        // R4: 15 highs, a low, then 16 highs; still bipolar throughout
        do_reset();
        pos_in = 1'b1; neg_in = 1'b0;
        uni_req = 1'b1;
        for (int k = 0; k < 15; k++) begin
            tick();
            chk("R4 bipolar while qualifying", 3'b100);
        end
        uni_req = 1'b0;
        tick();
        chk("R4 low sample restarts count", 3'b100);
        uni_req = 1'b1;
        for (int k = 0; k < 16; k++) begin
            tick();
            chk("R4 sixteen highs still bipolar", 3'b100);
        end
        neg_in = 1'b1; data_in = 1'b1;
        tick();
        chk("R4 unipolar after sixteen highs", 3'b000);
        tick();
        chk("R5 rails ignored in unipolar", 3'b000);
        uni_req = 1'b0;
        tick();
        chk("R4 low edge still unipolar", 3'b000);
        tick();
        chk("R4 back to bipolar", 3'b001);
        pos_in = 1'b0; neg_in = 1'b0; data_in = 1'b0;

        // pattern: all ones
        nbits = 40;
        for (int k = 0; k < nbits; k++) bits[k] = 1'b1;
        all_cfgs("ones");

        // pattern: all zeros
        for (int k = 0; k < nbits; k++) bits[k] = 1'b0;
        all_cfgs("zeros");

        // pattern: zero runs of many lengths
        idx = 0;
        for (int r = 0; r < 10; r++) begin
            bits[idx++] = 1'b1;
            if (r % 2 == 1) bits[idx++] = 1'b1;
            for (int z = 0; z < runs[r]; z++) bits[idx++] = 1'b0;
        end
        nbits = idx;
        all_cfgs("runs");

        // pattern: zero-biased pseudo-random
        lfsr = 16'hACE1;
        nbits = 96;
        for (int k = 0; k < nbits; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bits[k] = lfsr[0] & lfsr[5];
        end
        all_cfgs("lfsr");

        // R9: depth change mid-stream, AMI all ones
        sub_en = 1'b0; e1_mode = 1'b1;
        do_reset();
        qualify();
        c = 10;
        for (int k = 0; k < c + 16; k++) begin
            data_in = 1'b1;
            if (k == c) e1_mode = 1'b0;
            tick();
            if (k < 4 || (k >= c && k <= c + 8)) begin
                chk("R9 space around setting change", 3'b000);
            end else begin
                m = (k < c) ? (k - 4) : (c - 4) + (k - c - 9);
                chk("R9 polarity kept across change", (m % 2 == 0) ? 3'b100 : 3'b010);
            end
        end
        uni_req = 1'b0;
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule